// File: doc/BRIEF.md
# Pulse-Width Serial Boot Handshake

This block runs the handshake that opens a serial boot on a part whose clock has not been trimmed. The host encodes each bit as the length of a low pulse on the receive line. Before any data, the host sends two calibration pulses, one short and one long. The block measures them and sets its decision threshold halfway between them. It then takes a fixed run of data bits. It compares each one with a locally generated LFSR sequence that the host also knows.

If every received bit matches, the block replies with more of the same sequence and then a short version code. It times every transmit edge from the host's own receive edges, so neither side needs a baud rate. The outcome appears on three flags: done (a single-cycle pulse), fail (a bit mismatch) and timeout (the line went quiet). The loader that follows a successful handshake is outside this block.

Top module: `pw_lfsr_handshake`

## Requirements
- R1: While reset is asserted, tx_o is 1 and tx_oe_o is 0. From the first clock after reset is released, tx_oe_o stays 1 and tx_o stays 1. done_o, fail_o and timeout_o are 0 after reset.
- R2: The threshold is floor((d0 + d1) / 2). d0 and d1 are the low widths, in clock cycles, of the first two rx pulses.
- R3: After calibration, a pulse whose low width is below the threshold decodes as 1. A width equal to or above the threshold decodes as 0.
- R4: The LFSR is 32 bits and starts at 0x50. One advance shifts it left by one and puts the parity of (state AND 0xB2) into bit 0. Received data bit k (k from 0 to 249) must equal bit 0 of the state after k advances.
- R5: A received bit that does not match sets fail_o 3 cycles after the rx rising edge that ends the pulse. fail_o then stays 1 until reset. After a failure, tx_o stays 1 and done_o and timeout_o are never asserted.
- R6: After 250 good bits, the block sends 258 bits, continuing the same LFSR state. When 8 bits remain, the state is overwritten with the version id 0x52 before that bit is taken. Every transmitted bit is bit 0 of the state, and the state advances once per bit.
- R7: Each transmitted bit uses four rx edges. An rx fall drives tx_o to 0. The following rx rise drives tx_o to the bit. The next rx fall drives tx_o back to 1, and the next rx rise closes the bit. tx_o changes 3 cycles after rx_i changes.
- R8: Each edge wait has a timeout of TIMEOUT_CYC clock cycles (default 3,000,000). If it expires, timeout_o is set and stays set until reset, and the handshake stops.
- R9: done_o is 1 for exactly one cycle, 3 cycles after the rx rise that closes the last transmitted bit. No timeout can follow a completed handshake.
- R10: tx_o stays 1 through calibration and the whole receive phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Host receive line (asynchronous) |
| tx_o | output | 1 | Transmit line level |
| tx_oe_o | output | 1 | Transmit output enable |
| done_o | output | 1 | One-cycle pulse when the handshake completes |
| fail_o | output | 1 | Sticky: a received bit did not match |
| timeout_o | output | 1 | Sticky: an edge wait expired |

## Verification
A wrong threshold or a wrong LFSR state shows up as fail_o on the first bit it corrupts. That is 3 cycles after the rx rise ending the pulse, usually within the first few received bits. An error in the version load or in edge pacing appears at tx_o on the affected bit, again 3 cycles after the rx edge that should move it. A watchdog that is never armed shows as a missing timeout_o about TIMEOUT_CYC cycles into a quiet line. A watchdog that stays armed too long shows as a timeout_o after done_o or fail_o.

// File: rtl/pw_hs_pkg.sv
package pw_hs_pkg;
  typedef enum logic [3:0] {
    ST_CAL0,
    ST_CAL1,
    ST_RECV,
    ST_TX_LO,
    ST_TX_BIT,
    ST_TX_HI,
    ST_TX_END,
    ST_DONE,
    ST_FAIL,
    ST_TMO
  } hs_state_e;
endpackage

// File: rtl/pw_hs_rx_sync.sv
module pw_hs_rx_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic fall_o,
  output logic rise_o
);
  logic s1_q, s2_q, s3_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= 1'b1;
      s2_q <= 1'b1;
      s3_q <= 1'b1;
    end else begin
      s1_q <= rx_i;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign fall_o = s3_q & ~s2_q;
  assign rise_o = ~s3_q & s2_q;
endmodule

// File: rtl/pw_hs_pulse_timer.sv
module pw_hs_pulse_timer #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fall_i,
  output logic [CNT_W-1:0] width_o
);
  logic [CNT_W-1:0] cnt_q, stamp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      stamp_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      if (fall_i) stamp_q <= cnt_q;
    end
  end

  // valid in the cycle the rising edge is flagged
  assign width_o = cnt_q - stamp_q;
endmodule

// File: rtl/pw_hs_lfsr.sv
module pw_hs_lfsr #(
  parameter int unsigned           W    = 32,
  parameter logic        [W-1:0]   SEED = W'(32'h50),
  parameter logic        [W-1:0]   TAPS = W'(32'hB2)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         adv_i,
  output logic         bit_o
);
  logic [W-1:0] q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= SEED;
    else if (load_i) q <= load_val_i;
    else if (adv_i)  q <= {q[W-2:0], ^(q & TAPS)};
  end

  assign bit_o = q[0];
endmodule

// File: rtl/pw_hs_watchdog.sv
module pw_hs_watchdog #(
  parameter int unsigned LIMIT = 3_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic arm_i,
  input  logic kick_i,
  output logic expire_o
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!arm_i || kick_i)   cnt_q <= '0;
    else if (cnt_q != LAST)      cnt_q <= cnt_q + 1'b1;
  end

  assign expire_o = arm_i && !kick_i && (cnt_q == LAST);
endmodule

// File: rtl/pw_lfsr_handshake.sv
module pw_lfsr_handshake
  import pw_hs_pkg::*;
#(
  parameter int unsigned             CNT_W       = 32,
  parameter int unsigned             LFSR_W      = 32,
  parameter logic [LFSR_W-1:0]       LFSR_SEED   = LFSR_W'(32'h50),
  parameter logic [LFSR_W-1:0]       LFSR_TAPS   = LFSR_W'(32'hB2),
  parameter int unsigned             RX_BITS     = 250,
  parameter int unsigned             VER_BITS    = 8,
  parameter logic [VER_BITS-1:0]     VERSION_ID  = VER_BITS'(8'h52),
  parameter int unsigned             TIMEOUT_CYC = 3_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rx_i,
  output logic tx_o,
  output logic tx_oe_o,
  output logic done_o,
  output logic fail_o,
  output logic timeout_o
);
  localparam int unsigned TX_BITS = RX_BITS + VER_BITS;
  localparam int unsigned RX_CW   = $clog2(RX_BITS + 1);
  localparam int unsigned TX_CW   = $clog2(TX_BITS + 1);
  localparam logic [RX_CW-1:0] RX_INIT = RX_CW'(RX_BITS);
  localparam logic [TX_CW-1:0] TX_INIT = TX_CW'(TX_BITS);
  localparam logic [TX_CW-1:0] VER_AT  = TX_CW'(VER_BITS);
  localparam logic [LFSR_W-1:0] VER_LOAD = LFSR_W'(VERSION_ID);

  hs_state_e        state_q;
  logic             low_seen_q;
  logic [CNT_W-1:0] cal0_q, thr_q;
  logic [RX_CW-1:0] rx_left_q;
  logic [TX_CW-1:0] tx_left_q;
  logic             tx_bit_q, tx_q, oe_q, done_q, fail_q, tmo_q;

  logic             fall, rise, expire, lfsr_bit, lfsr_adv, lfsr_load;
  logic             meas_done, rx_bit, armed;
  logic [CNT_W-1:0] width;
  logic [CNT_W:0]   cal_sum;

  pw_hs_rx_sync u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .rx_i(rx_i),
    .fall_o(fall), .rise_o(rise)
  );

  pw_hs_pulse_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .fall_i(fall), .width_o(width)
  );

  pw_hs_lfsr #(.W(LFSR_W), .SEED(LFSR_SEED), .TAPS(LFSR_TAPS)) u_lfsr (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(lfsr_load),
    .load_val_i(VER_LOAD), .adv_i(lfsr_adv), .bit_o(lfsr_bit)
  );

  pw_hs_watchdog #(.LIMIT(TIMEOUT_CYC)) u_wdog (
    .clk_i(clk_i), .rst_ni(rst_ni), .arm_i(armed),
    .kick_i(fall | rise), .expire_o(expire)
  );

  always_comb begin
    armed     = (state_q != ST_DONE) && (state_q != ST_FAIL) && (state_q != ST_TMO);
    meas_done = rise && low_seen_q;
    rx_bit    = (width < thr_q);
    cal_sum   = {1'b0, cal0_q} + {1'b0, width};
    lfsr_adv  = ((state_q == ST_RECV) && meas_done) || ((state_q == ST_TX_HI) && fall);
    lfsr_load = (state_q == ST_TX_LO) && fall && (tx_left_q == VER_AT);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_CAL0;
      low_seen_q <= 1'b0;
      cal0_q     <= '0;
      thr_q      <= '0;
      rx_left_q  <= RX_INIT;
      tx_left_q  <= TX_INIT;
      tx_bit_q   <= 1'b1;
      tx_q       <= 1'b1;
      oe_q       <= 1'b0;
      done_q     <= 1'b0;
      fail_q     <= 1'b0;
      tmo_q      <= 1'b0;
    end else begin
      oe_q   <= 1'b1;
      done_q <= 1'b0;
      if (expire) begin
        state_q <= ST_TMO;
        tmo_q   <= 1'b1;
      end else begin
        unique case (state_q)
          ST_CAL0, ST_CAL1, ST_RECV: begin
            if (fall) low_seen_q <= 1'b1;
            if (meas_done) begin
              low_seen_q <= 1'b0;
              if (state_q == ST_CAL0) begin
                cal0_q  <= width;
                state_q <= ST_CAL1;
              end else if (state_q == ST_CAL1) begin
                thr_q   <= cal_sum[CNT_W:1];
                state_q <= ST_RECV;
              end else if (rx_bit != lfsr_bit) begin
                fail_q  <= 1'b1;
                state_q <= ST_FAIL;
              end else if (rx_left_q == RX_CW'(1)) begin
                state_q <= ST_TX_LO;
              end else begin
                rx_left_q <= rx_left_q - 1'b1;
              end
            end
          end
          ST_TX_LO: if (fall) begin
            tx_q     <= 1'b0;
            tx_bit_q <= (tx_left_q == VER_AT) ? VERSION_ID[0] : lfsr_bit;
            state_q  <= ST_TX_BIT;
          end
          ST_TX_BIT: if (rise) begin
            tx_q    <= tx_bit_q;
            state_q <= ST_TX_HI;
          end
          ST_TX_HI: if (fall) begin
            tx_q    <= 1'b1;
            state_q <= ST_TX_END;
          end
          ST_TX_END: if (rise) begin
            if (tx_left_q == TX_CW'(1)) begin
              done_q  <= 1'b1;
              state_q <= ST_DONE;
            end else begin
              tx_left_q <= tx_left_q - 1'b1;
              state_q   <= ST_TX_LO;
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign tx_o      = tx_q;
  assign tx_oe_o   = oe_q;
  assign done_o    = done_q;
  assign fail_o    = fail_q;
  assign timeout_o = tmo_q;
endmodule

// File: rtl/pw_lfsr_handshake_chk.sv
module pw_lfsr_handshake_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tx_o,
  input logic tx_oe_o,
  input logic done_o,
  input logic fail_o,
  input logic timeout_o
);
  p_oe_held_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_oe_o |=> tx_oe_o);

  p_fail_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |=> fail_o);

  p_fail_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> (tx_o && !done_o && !timeout_o));

  p_timeout_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |=> timeout_o);

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_one_outcome_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, fail_o, timeout_o}));
endmodule

bind pw_lfsr_handshake pw_lfsr_handshake_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tx_o     (tx_o),
  .tx_oe_o  (tx_oe_o),
  .done_o   (done_o),
  .fail_o   (fail_o),
  .timeout_o(timeout_o)
);

// File: tb/pw_lfsr_handshake_test.sv
`timescale 1ns/1ps
module pw_lfsr_handshake_test;
  localparam int unsigned TMO  = 400;
  localparam int unsigned NRX  = 250;
  localparam int unsigned NTX  = 258;
  localparam int unsigned GAP  = 6;
  localparam int unsigned HALF = 6;
  localparam int unsigned NV   = 3;
  // cal0, cal1, width for a 1, width for a 0
  localparam int unsigned VEC [NV][4] = '{
    '{6, 18, 6, 18},
    '{11, 30, 19, 20},
    '{8, 8, 4, 8}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic rx_i = 1'b1;
  logic tx_o, tx_oe_o, done_o, fail_o, timeout_o;
  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  pw_lfsr_handshake #(.TIMEOUT_CYC(TMO)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .rx_i(rx_i), .tx_o(tx_o),
    .tx_oe_o(tx_oe_o), .done_o(done_o), .fail_o(fail_o), .timeout_o(timeout_o)
  );

  function automatic logic [31:0] step(logic [31:0] m);
    return {m[30:0], ^(m & 32'hB2)};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rx_i   = 1'b1;
    rst_ni = 1'b0;
    wait_n(2);
    rst_ni = 1'b1;
    wait_n(2);
  endtask

  task automatic pulse(int w);
    rx_i = 1'b0;
    wait_n(w);
    rx_i = 1'b1;
    wait_n(GAP);
  endtask

  // calibration plus n correct data bits; returns LFSR model state
  task automatic send_good(int v, int n, output logic [31:0] m);
    pulse(VEC[v][0]);
    pulse(VEC[v][1]);
    m = 32'h50;
    for (int k = 0; k < n; k++) begin
      pulse(m[0] ? VEC[v][2] : VEC[v][3]);
      m = step(m);
    end
  endtask

  task automatic run_vector(int v);
    logic [31:0] m;
    logic b;
    do_reset();
    send_good(v, NRX, m);
    chk("R3 R4 no fail after receive", fail_o, 0);
    chk("R10 tx high after receive", tx_o, 1);
    for (int cnt = NTX; cnt >= 1; cnt--) begin
      if (cnt == 8) m = 32'h52;
      b = m[0];
      rx_i = 1'b0;
      wait_n(2);
      chk("R7 tx not yet low", tx_o, 1);
      wait_n(HALF - 2);
      chk("R7 tx low on rx fall", tx_o, 0);
      rx_i = 1'b1;
      wait_n(HALF);
      chk("R6 tx bit", tx_o, b);
      rx_i = 1'b0;
      wait_n(HALF);
      chk("R7 tx high on second fall", tx_o, 1);
      m = step(m);
      rx_i = 1'b1;
      if (cnt == 1) begin
        wait_n(2);
        chk("R9 done not early", done_o, 0);
        wait_n(1);
        chk("R9 done pulse", done_o, 1);
        wait_n(1);
        chk("R9 done one cycle", done_o, 0);
      end else begin
        wait_n(HALF);
      end
    end
    chk("R5 no fail in good run", fail_o, 0);
    wait_n(TMO + 50);
    chk("R9 no timeout after done", timeout_o, 0);
    chk("R9 done stays low", done_o, 0);
  endtask

  task automatic run_all();
    logic [31:0] m;
    // R1 reset state
    @(negedge clk);
    rst_ni = 1'b0;
    wait_n(2);
    chk("R1 oe low in reset", tx_oe_o, 0);
    chk("R1 tx high in reset", tx_o, 1);
    rst_ni = 1'b1;
    wait_n(2);
    chk("R1 oe after reset", tx_oe_o, 1);
    chk("R1 tx after reset", tx_o, 1);
    chk("R1 flags after reset", {done_o, fail_o, timeout_o}, 0);

    for (int v = 0; v < NV; v++) run_vector(v);

    // R5 mismatch on first bit (expected 0, send short = 1)
    do_reset();
    pulse(6);
    pulse(18);
    rx_i = 1'b0;
    wait_n(6);
    rx_i = 1'b1;
    wait_n(2);
    chk("R5 fail not early", fail_o, 0);
    wait_n(1);
    chk("R5 fail on mismatch", fail_o, 1);
    wait_n(GAP);
    for (int k = 0; k < 6; k++) pulse(10);
    chk("R5 fail sticky", fail_o, 1);
    chk("R5 tx high after fail", tx_o, 1);
    chk("R5 no done after fail", done_o, 0);
    wait_n(TMO + 50);
    chk("R5 no timeout after fail", timeout_o, 0);

    // R5 R2 mismatch at bit 5 with odd calibration sum (threshold 20)
    do_reset();
    send_good(1, 5, m);
    chk("R2 good bits at boundary widths", fail_o, 0);
    pulse(m[0] ? VEC[1][3] : VEC[1][2]);
    chk("R5 fail at bit 5", fail_o, 1);

    // R8 idle line timeout
    do_reset();
    wait_n(TMO - 20);
    chk("R8 no early timeout", timeout_o, 0);
    wait_n(40);
    chk("R8 idle timeout", timeout_o, 1);
    chk("R8 tx high on timeout", tx_o, 1);

    // R8 rx held low during calibration
    do_reset();
    rx_i = 1'b0;
    wait_n(TMO + 30);
    chk("R8 timeout with rx low", timeout_o, 1);
    rx_i = 1'b1;
    wait_n(GAP);
    chk("R8 timeout sticky", timeout_o, 1);

    // R8 stall in transmit phase
    do_reset();
    send_good(0, NRX, m);
    rx_i = 1'b0;
    wait_n(HALF);
    chk("R7 first tx low", tx_o, 0);
    wait_n(TMO + 30);
    chk("R8 timeout in tx phase", timeout_o, 1);
    chk("R8 no done on timeout", done_o, 0);
    chk("R8 no fail on timeout", fail_o, 0);
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog actual=hung expected=finished");
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule